// File: doc/BRIEF.md
# Byte-level I2C serial EEPROM target

This block is the storage side of a small I2C serial EEPROM of the 24Cxx kind. A separate front end decodes the bus bits and hands it byte-level events: a start with the 7-bit device address, a written byte, a request for a read byte, and a stop. The block keeps a byte memory of parameterisable size and one word-address register. The device address bits below the block size select the upper word-address bits, so one instance answers on a run of consecutive bus addresses. For the default 2048-byte part this run is eight addresses, from 0x50 to 0x57.

Inside a transaction, the first written byte sets the low part of the word address. Each later written byte is stored at that address. A read returns the byte at the current address. The address steps by one after every data byte, whether it was read or written, and wraps from the last location to zero. A write-protect input blocks stores and turns the acknowledge into a not-acknowledge. The address still advances while writes are blocked.

After reset the block spends one cycle per location filling the memory with 8'hFF. It raises `ready_o` when the fill is done. Strobes that arrive before then are ignored. At most one strobe is expected per cycle. If several arrive together, start wins over stop, stop over write, and write over read.

Top module: `i2c_eeprom_target`

## Requirements
- R1: After reset `ready_o` stays low for exactly MEM_BYTES clock cycles and then stays high. Strobes given while it is low have no effect. Every location reads 8'hFF until it is written.
- R2: A start whose device address matches BASE_ADDR on every bit above the low log2(MEM_BYTES)-8 bits selects the device (0x50..0x57 by default). The start loads the word address with those low device bits as its upper bits and zero as its low 8 bits, and re-enters the word-address phase.
- R3: The first byte written after a selecting start sets the word address to {low device-address bits, byte}. It is acknowledged with `ack_valid_o`=1 and `ack_o`=1 one cycle later, and later writes become data writes.
- R4: In the data phase, a written byte is stored at the current word address and acknowledged with `ack_o`=1. The address then increments.
- R5: While `wp_i` is 1, a data-phase write stores nothing and is answered with `ack_o`=0. The word address still increments.
- R6: A read strobe on a selected device gives `rd_valid_o`=1 one cycle later, with `rd_data_o` holding the byte at the current word address. The address then increments.
- R7: Incrementing past the last location (MEM_BYTES-1) gives address 0, for both reads and writes.
- R8: A read issued after a start and before any written byte uses the address loaded by the start (current-address read).
- R9: While no device is selected (a non-matching start, or any time after a stop), writes and reads produce no `ack_valid_o` and no `rd_valid_o`, and they leave the memory unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start strobe, carries dev_addr_i |
| stop_i | input | 1 | Stop strobe |
| wr_i | input | 1 | Written-byte strobe |
| rd_i | input | 1 | Read-byte request strobe |
| dev_addr_i | input | 7 | Device address sampled with start_i |
| wr_data_i | input | 8 | Byte sampled with wr_i |
| wp_i | input | 1 | Write protect |
| ready_o | output | 1 | Fill after reset complete |
| ack_valid_o | output | 1 | Write response valid |
| ack_o | output | 1 | 1 = acknowledge, 0 = not-acknowledge |
| rd_valid_o | output | 1 | Read data valid |
| rd_data_o | output | 8 | Read byte |

## Verification
The main path is driven with several transaction shapes. A random write followed by a sequential read, both on an inner device address, shows that the low device bits reach the upper word-address bits. A current-address read straight after a start separates the start-loaded address from a stale one. A sequential write and a sequential read that both cross the top location show wrap-around in each direction. Protected writes, a non-matching device address and traffic after a stop each show that data is kept and no response appears. A fresh read then confirms that the memory was not touched.

// File: rtl/eeprom_tgt_pkg.sv
package eeprom_tgt_pkg;
  typedef enum logic {
    PH_WORD = 1'b0,
    PH_DATA = 1'b1
  } byte_phase_t;

  localparam logic [7:0] ERASED_BYTE = 8'hFF;
endpackage

// File: rtl/eeprom_tgt_store.sv
module eeprom_tgt_store #(
  parameter int MEM_BYTES = 2048,
  localparam int AW = $clog2(MEM_BYTES)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata,
  output logic          ready
);
  import eeprom_tgt_pkg::*;

  logic [7:0]    mem [MEM_BYTES];
  logic          filling;
  logic [AW-1:0] fill_ptr;

  logic          port_we;
  logic [AW-1:0] port_addr;
  logic [7:0]    port_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      filling  <= 1'b1;
      fill_ptr <= '0;
    end else if (filling) begin
      fill_ptr <= fill_ptr + 1'b1;
      if (fill_ptr == AW'(MEM_BYTES - 1)) filling <= 1'b0;
    end
  end

  assign ready = ~filling;

  always_comb begin
    port_we   = filling ? !rst : we;
    port_addr = filling ? fill_ptr : waddr;
    port_data = filling ? ERASED_BYTE : wdata;
  end

  always_ff @(posedge clk) begin
    if (port_we) mem[port_addr] <= port_data;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/eeprom_tgt_addr.sv
module eeprom_tgt_addr #(
  parameter int          MEM_BYTES = 2048,
  parameter logic [6:0]  BASE_ADDR = 7'h50,
  localparam int AW      = $clog2(MEM_BYTES),
  localparam int DEV_LOW = (AW > 8) ? AW - 8 : 0
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      ready,
  input  logic                      start_i,
  input  logic                      stop_i,
  input  logic                      wr_i,
  input  logic                      rd_i,
  input  logic [6:0]                dev_addr_i,
  input  logic [7:0]                wr_data_i,
  input  logic                      wp_i,
  output logic [AW-1:0]             word_addr,
  output eeprom_tgt_pkg::byte_phase_t phase,
  output logic                      selected,
  output logic                      store_en,
  output logic                      fetch_en,
  output logic                      ack_valid,
  output logic                      ack
);
  import eeprom_tgt_pkg::*;

  logic          do_start, do_stop, do_wr, do_rd;
  logic          dev_match;
  logic [14:0]   start_wide;
  logic [14:0]   word_wide;
  logic [AW-1:0] next_addr;

  always_comb begin
    do_start = ready && start_i;
    do_stop  = ready && !start_i && stop_i;
    do_wr    = ready && !start_i && !stop_i && wr_i && selected;
    do_rd    = ready && !start_i && !stop_i && !wr_i && rd_i && selected;
    dev_match  = (dev_addr_i >> DEV_LOW) == (BASE_ADDR >> DEV_LOW);
    start_wide = {dev_addr_i, 8'h00};
    word_wide  = {dev_addr_i, wr_data_i};
    next_addr  = word_addr + 1'b1;
    store_en   = do_wr && (phase == PH_DATA) && !wp_i;
    fetch_en   = do_rd;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      word_addr <= '0;
      phase     <= PH_WORD;
      selected  <= 1'b0;
      ack_valid <= 1'b0;
      ack       <= 1'b0;
    end else begin
      ack_valid <= do_wr;
      ack       <= 1'b0;
      if (do_start) begin
        selected  <= dev_match;
        word_addr <= start_wide[AW-1:0];
        phase     <= PH_WORD;
      end else if (do_stop) begin
        selected <= 1'b0;
      end else if (do_wr) begin
        if (phase == PH_WORD) begin
          word_addr <= word_wide[AW-1:0];
          phase     <= PH_DATA;
          ack       <= 1'b1;
        end else begin
          word_addr <= next_addr;
          ack       <= !wp_i;
        end
      end else if (do_rd) begin
        word_addr <= next_addr;
      end
    end
  end
endmodule

// File: rtl/i2c_eeprom_target.sv
module i2c_eeprom_target #(
  parameter int         MEM_BYTES = 2048,
  parameter logic [6:0] BASE_ADDR = 7'h50,
  localparam int AW = $clog2(MEM_BYTES)
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start_i,
  input  logic       stop_i,
  input  logic       wr_i,
  input  logic       rd_i,
  input  logic [6:0] dev_addr_i,
  input  logic [7:0] wr_data_i,
  input  logic       wp_i,
  output logic       ready_o,
  output logic       ack_valid_o,
  output logic       ack_o,
  output logic       rd_valid_o,
  output logic [7:0] rd_data_o
);
  import eeprom_tgt_pkg::*;

  logic          ready;
  logic [AW-1:0] word_addr;
  byte_phase_t   phase;
  logic          selected;
  logic          store_en;
  logic          fetch_en;
  logic          rd_pending;

  eeprom_tgt_addr #(
    .MEM_BYTES(MEM_BYTES),
    .BASE_ADDR(BASE_ADDR)
  ) u_addr (
    .clk       (clk),
    .rst       (rst),
    .ready     (ready),
    .start_i   (start_i),
    .stop_i    (stop_i),
    .wr_i      (wr_i),
    .rd_i      (rd_i),
    .dev_addr_i(dev_addr_i),
    .wr_data_i (wr_data_i),
    .wp_i      (wp_i),
    .word_addr (word_addr),
    .phase     (phase),
    .selected  (selected),
    .store_en  (store_en),
    .fetch_en  (fetch_en),
    .ack_valid (ack_valid_o),
    .ack       (ack_o)
  );

  eeprom_tgt_store #(
    .MEM_BYTES(MEM_BYTES)
  ) u_store (
    .clk  (clk),
    .rst  (rst),
    .we   (store_en),
    .waddr(word_addr),
    .wdata(wr_data_i),
    .re   (fetch_en),
    .raddr(word_addr),
    .rdata(rd_data_o),
    .ready(ready)
  );

  always_ff @(posedge clk) begin
    if (rst) rd_pending <= 1'b0;
    else     rd_pending <= fetch_en;
  end

  assign rd_valid_o = rd_pending;
  assign ready_o    = ready;
endmodule

// File: rtl/i2c_eeprom_target_chk.sv
module i2c_eeprom_target_chk #(
  parameter int AW = 11
) (
  input logic                        clk,
  input logic                        rst,
  input logic                        start_i,
  input logic                        stop_i,
  input logic                        wr_i,
  input logic                        rd_i,
  input logic                        wp_i,
  input logic                        ready_o,
  input logic                        ack_valid_o,
  input logic                        ack_o,
  input logic                        rd_valid_o,
  input logic [AW-1:0]               word_addr,
  input eeprom_tgt_pkg::byte_phase_t phase,
  input logic                        selected
);
  import eeprom_tgt_pkg::*;

  logic plain_wr, plain_rd;
  assign plain_wr = ready_o && selected && !start_i && !stop_i && wr_i;
  assign plain_rd = ready_o && selected && !start_i && !stop_i && !wr_i && rd_i;

  // R1
  ready_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ready_o |=> ready_o);

  // R1
  fill_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !ready_o |=> (!ack_valid_o && !rd_valid_o));

  // R3
  word_phase_chk: assert property (@(posedge clk) disable iff (rst)
    (plain_wr && phase == PH_WORD) |=> (phase == PH_DATA && ack_valid_o && ack_o));

  // R5
  wp_nack_chk: assert property (@(posedge clk) disable iff (rst)
    (plain_wr && phase == PH_DATA && wp_i) |=> (ack_valid_o && !ack_o));

  // R6
  rd_latency_chk: assert property (@(posedge clk) disable iff (rst)
    plain_rd |=> rd_valid_o);

  // R7
  wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (plain_rd && word_addr == '1) |=> (word_addr == '0));

  // R9
  unsel_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!selected && !start_i) |=> (!ack_valid_o && !rd_valid_o));
endmodule

bind i2c_eeprom_target i2c_eeprom_target_chk #(.AW(AW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .start_i    (start_i),
  .stop_i     (stop_i),
  .wr_i       (wr_i),
  .rd_i       (rd_i),
  .wp_i       (wp_i),
  .ready_o    (ready_o),
  .ack_valid_o(ack_valid_o),
  .ack_o      (ack_o),
  .rd_valid_o (rd_valid_o),
  .word_addr  (word_addr),
  .phase      (phase),
  .selected   (selected)
);

// File: tb/tb_i2c_eeprom_target.sv
module tb_i2c_eeprom_target;
  localparam int CLK_PERIOD = 10;
  localparam int MEM_BYTES  = 2048;
  localparam int MASK       = MEM_BYTES - 1;
  localparam int BASE       = 'h50;
  localparam int DEV_LOW    = 3;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start_i = 0, stop_i = 0, wr_i = 0, rd_i = 0, wp_i = 0;
  logic [6:0] dev_addr_i = '0;
  logic [7:0] wr_data_i = '0;
  logic       ready_o, ack_valid_o, ack_o, rd_valid_o;
  logic [7:0] rd_data_o;

  int checks = 0;
  int fails  = 0;

  int  mem_m [MEM_BYTES];
  int  addr_m = 0;
  bit  sel_m = 0;
  bit  data_ph_m = 0;
  bit  ready_m = 0;
  int  fill_cnt = 0;
  bit  exp_av, exp_ack, exp_rdv;
  int  exp_rd;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_eeprom_target #(.MEM_BYTES(MEM_BYTES), .BASE_ADDR(7'h50)) dut (
    .clk(clk), .rst(rst), .start_i(start_i), .stop_i(stop_i), .wr_i(wr_i),
    .rd_i(rd_i), .dev_addr_i(dev_addr_i), .wr_data_i(wr_data_i), .wp_i(wp_i),
    .ready_o(ready_o), .ack_valid_o(ack_valid_o), .ack_o(ack_o),
    .rd_valid_o(rd_valid_o), .rd_data_o(rd_data_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, expv, $time);
    end
  endtask

  // one clock: drive at negedge, model, compare at next negedge
  task automatic step(input bit s, input bit p, input bit w, input bit r,
                      input int d, input int b, input string req);
    start_i = s; stop_i = p; wr_i = w; rd_i = r;
    dev_addr_i = 7'(d); wr_data_i = 8'(b);
    exp_av = 0; exp_ack = 0; exp_rdv = 0; exp_rd = 0;
    if (ready_m) begin
      if (s) begin
        sel_m = ((d >> DEV_LOW) == (BASE >> DEV_LOW));
        addr_m = (d << 8) & MASK;
        data_ph_m = 0;
      end else if (p) begin
        sel_m = 0;
      end else if (w && sel_m) begin
        exp_av = 1;
        if (!data_ph_m) begin
          addr_m = ((d << 8) | b) & MASK;
          data_ph_m = 1;
          exp_ack = 1;
        end else begin
          if (!wp_i) mem_m[addr_m] = b;
          exp_ack = !wp_i;
          addr_m = (addr_m + 1 > MASK) ? 0 : addr_m + 1;
        end
      end else if (r && sel_m) begin
        exp_rdv = 1;
        exp_rd = mem_m[addr_m];
        addr_m = (addr_m + 1 > MASK) ? 0 : addr_m + 1;
      end
    end else if (!rst) begin
      fill_cnt++;
      if (fill_cnt == MEM_BYTES) ready_m = 1;
    end
    @(posedge clk);
    @(negedge clk);
    start_i = 0; stop_i = 0; wr_i = 0; rd_i = 0;
    chk(ready_o == ready_m, {req, " ready"}, ready_o, ready_m);
    chk(ack_valid_o == exp_av, {req, " ack_valid"}, ack_valid_o, exp_av);
    chk(rd_valid_o == exp_rdv, {req, " rd_valid"}, rd_valid_o, exp_rdv);
    if (exp_av) chk(ack_o == exp_ack, {req, " ack"}, ack_o, exp_ack);
    if (exp_rdv) chk(rd_data_o == 8'(exp_rd), {req, " rd_data"}, rd_data_o, exp_rd);
  endtask

  task automatic idle(input string req);
    step(0, 0, 0, 0, 0, 0, req);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < MEM_BYTES; i++) mem_m[i] = 'hFF;
    @(negedge clk);
    idle("R1 reset"); idle("R1 reset");
    rst = 0;
    // R1: strobes during the fill are ignored
    step(1, 0, 0, 0, 'h50, 0, "R1 fill start");
    step(0, 0, 1, 0, 0, 'h00, "R1 fill wr");
    step(0, 0, 1, 0, 0, 'hAB, "R1 fill data");
    step(0, 0, 0, 1, 0, 0, "R1 fill rd");
    while (!ready_m) idle("R1 fill");
    idle("R1 ready");
    // R8 + R1: current-address read after start, erased contents
    step(1, 0, 0, 0, 'h50, 0, "R8 start");
    step(0, 0, 0, 1, 0, 0, "R8 read0");
    step(0, 0, 0, 1, 0, 0, "R8 read1");
    step(0, 1, 0, 0, 0, 0, "R8 stop");
    // R3 R4: random + sequential write on inner device address
    step(1, 0, 0, 0, 'h52, 0, "R2 start");
    step(0, 0, 1, 0, 'h52, 'h10, "R3 word");
    step(0, 0, 1, 0, 'h52, 'hA1, "R4 data");
    step(0, 0, 1, 0, 'h52, 'hA2, "R4 data");
    step(0, 0, 1, 0, 'h52, 'hA3, "R4 data");
    step(0, 1, 0, 0, 0, 0, "R4 stop");
    // R6: random then sequential read
    step(1, 0, 0, 0, 'h52, 0, "R6 start");
    step(0, 0, 1, 0, 'h52, 'h10, "R6 word");
    for (int k = 0; k < 4; k++) step(0, 0, 0, 1, 0, 0, "R6 seqread");
    step(0, 1, 0, 0, 0, 0, "R6 stop");
    // R2: start loads device bits as upper address
    step(1, 0, 0, 0, 'h52, 0, "R2 start");
    step(0, 0, 0, 1, 0, 0, "R2 curread");
    step(0, 1, 0, 0, 0, 0, "R2 stop");
    // R5: write protect
    wp_i = 1;
    step(1, 0, 0, 0, 'h52, 0, "R5 start");
    step(0, 0, 1, 0, 'h52, 'h11, "R5 word");
    step(0, 0, 1, 0, 'h52, 'h55, "R5 blocked");
    step(0, 0, 1, 0, 'h52, 'h66, "R5 blocked");
    step(0, 0, 0, 1, 0, 0, "R5 rd after");
    wp_i = 0;
    step(1, 0, 0, 0, 'h52, 0, "R5 restart");
    step(0, 0, 1, 0, 'h52, 'h10, "R5 word");
    for (int k = 0; k < 4; k++) step(0, 0, 0, 1, 0, 0, "R5 kept");
    step(0, 1, 0, 0, 0, 0, "R5 stop");
    // R7: write wrap
    step(1, 0, 0, 0, 'h57, 0, "R7 start");
    step(0, 0, 1, 0, 'h57, 'hFE, "R7 word");
    step(0, 0, 1, 0, 0, 'h11, "R7 wdata");
    step(0, 0, 1, 0, 0, 'h22, "R7 wdata");
    step(0, 0, 1, 0, 0, 'h33, "R7 wdata wrap");
    step(0, 1, 0, 0, 0, 0, "R7 stop");
    step(1, 0, 0, 0, 'h50, 0, "R7 start0");
    step(0, 0, 0, 1, 0, 0, "R7 read0");
    step(0, 1, 0, 0, 0, 0, "R7 stop");
    // R7: read wrap
    step(1, 0, 0, 0, 'h57, 0, "R7 start");
    step(0, 0, 1, 0, 'h57, 'hFF, "R7 word");
    step(0, 0, 0, 1, 0, 0, "R7 rtop");
    step(0, 0, 0, 1, 0, 0, "R7 rwrap");
    step(0, 0, 0, 1, 0, 0, "R7 rnext");
    step(0, 1, 0, 0, 0, 0, "R7 stop");
    // R9: non-matching device and traffic after stop
    step(1, 0, 0, 0, 'h48, 0, "R9 start other");
    step(0, 0, 1, 0, 'h48, 'h00, "R9 wr other");
    step(0, 0, 1, 0, 'h48, 'h99, "R9 wr other");
    step(0, 0, 0, 1, 0, 0, "R9 rd other");
    step(0, 1, 0, 0, 0, 0, "R9 stop");
    step(0, 0, 1, 0, 'h50, 'h77, "R9 wr idle");
    step(0, 0, 0, 1, 0, 0, "R9 rd idle");
    step(1, 0, 0, 0, 'h50, 0, "R9 start");
    step(0, 0, 1, 0, 'h50, 'h00, "R9 word");
    step(0, 0, 0, 1, 0, 0, "R9 unchanged0");
    step(0, 0, 0, 1, 0, 0, "R9 unchanged1");
    step(0, 1, 0, 0, 0, 0, "R9 stop");
    idle("end");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule